// File: doc/BRIEF.md
# Magic-Sequence Watchdog Timer with Reset Cause

This block is a memory-mapped watchdog for a system that must prove it is still alive. Software selects a timeout as a power of two of watchdog ticks through a 5-bit delay field, sets an enable bit, and then services the watchdog by writing two fixed 32-bit magic words to two separate registers, in a set order. If the timer runs out, or if software writes a wrong word or the words out of order, the block raises a reset request for a fixed number of clock cycles.

The block keeps a 3-bit code that says why the last reset happened: power-on, expiry, bad service sequence, software-requested reset, or external user reset. Its own reset requests do not clear this code, so software can read it after the system restarts. Changes to the configuration register are staged. They reach the running timer only when a complete, correct service sequence is written. This also means that clearing the enable bit stops the timer only after the next correct service.

A control state machine has three states: IDLE (timer stopped), RUN (timer counting) and PULSE (reset request asserted). Its transitions are:
- IDLE to RUN on a valid service when the staged enable is 1.
- RUN to IDLE on a valid service when the staged enable is 0.
- RUN to PULSE on expiry, on a bad service sequence, or on a soft-reset write.
- IDLE to PULSE on a soft-reset write.
- PULSE to IDLE when the pulse count ends.
- Any state to IDLE on the user-reset input.

A second, two-state sequence checker (WAIT, ARMED) follows the magic-word writes.

Top module: `seqkick_wdt`

## Requirements
- R1: After power-on reset (`rst_n` low), the cause code reads 0, the config register reads 0, the timer is stopped and `rst_req` is low.
- R2: The register window is word-addressed, and `addr[1:0]` must be 0. Offset 0x0 is the soft-reset register, 0x4 is config, 0x8 is service word A, and 0xC is service word B. Config bit 31 is the enable and bits [4:0] are the delay. Reading config returns those fields with all other bits 0. Reading offset 0x0 or 0xC returns 0. `rdata` is valid in the cycle after `rd_en` and is 0 otherwise.
- R3: With the timer running at delay d, `rst_req` rises on the 2^(d+1)-th tick after the last valid service, and the cause becomes 1. Writing the config register alone never starts or changes the running timer.
- R4: A valid service is 0xABCD1234 written to 0x8, followed later by 0x4321DCBA written to 0xC. Other register accesses in between do not break the sequence. A valid service restarts the count from zero.
- R5: While the timer runs, a wrong word written to 0x8, a wrong word written to 0xC, or a write to 0xC without a prior correct write to 0x8 raises `rst_req` in the next cycle with cause 2. While the timer is stopped, such writes have no effect.
- R6: Clearing the enable bit while the timer runs does not stop it. It stops only at the next valid service.
- R7: Writing a value with bit 0 set to offset 0x0 raises `rst_req` in the next cycle with cause 3, whether the timer is running or stopped. Writing with bit 0 clear has no effect.
- R8: `rst_req` stays high for exactly PULSE_LEN cycles, which is 4 by default. Afterwards the timer is stopped and the config enable bit reads 0, while the delay field keeps its value.
- R9: A one-cycle pulse on `user_rst` stops the timer, clears config to 0, sets the cause to 4 and does not raise `rst_req`.
- R10: The cause code reads at offset 0x8, bits [2:0]. It changes only on power-on reset, on the start of a reset request, or on `user_rst`.
- R11: The timer advances only in cycles where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | One-cycle watchdog clock tick enable |
| user_rst | input | 1 | Pulse that reports an external user reset |
| addr | input | 4 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rst_req | output | 1 | Reset request pulse |

## Verification
A wrong control state shows up at `rst_req` itself, on a cycle-exact count. The bench counts ticks from the service edge, so a timer that reloads late, or one that takes a staged config too early, moves the rising edge by at least one cycle. A sequence checker stuck in the wrong state shows up the cycle after the second magic write, as either a spurious pulse or a missing one. A cause register that is overwritten, or not latched, shows up on the next read of offset 0x8, which the bench performs right after each pulse and after each reset.

// File: rtl/seqkick_pkg.sv
package seqkick_pkg;

    localparam int DELAY_W = 5;
    localparam int DATA_W  = 32;
    localparam int CAUSE_W = 3;

    localparam logic [DATA_W-1:0] KICK_A_WORD = 32'hABCD1234;
    localparam logic [DATA_W-1:0] KICK_B_WORD = 32'h4321DCBA;

    typedef enum logic [1:0] {
        OFS_SOFT  = 2'd0,
        OFS_CFG   = 2'd1,
        OFS_KICKA = 2'd2,
        OFS_KICKB = 2'd3
    } reg_ofs_e;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_POWER   = 3'd0,
        CAUSE_EXPIRE  = 3'd1,
        CAUSE_BADKICK = 3'd2,
        CAUSE_SOFT    = 3'd3,
        CAUSE_USER    = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_PULSE = 2'd2
    } ctrl_state_e;

    typedef enum logic {
        TK_WAIT  = 1'b0,
        TK_ARMED = 1'b1
    } kick_state_e;

    typedef struct packed {
        logic               en;
        logic [DELAY_W-1:0] delay;
    } wdt_cfg_t;

endpackage

// File: rtl/seqkick_regs.sv
module seqkick_regs
    import seqkick_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic               wbit_en,
    input  logic [DELAY_W-1:0] wbit_delay,
    input  logic               wbit_soft,
    input  logic [CAUSE_W-1:0] cause_i,
    input  logic               cfg_clr_i,
    input  logic               en_clr_i,
    output wdt_cfg_t           cfg_o,
    output logic               soft_wr_o,
    output logic               kick_a_wr_o,
    output logic               kick_b_wr_o,
    output logic [DATA_W-1:0]  rdata
);

    localparam int IDX_LSB = 2;
    localparam int PAD_W   = DATA_W - 1 - DELAY_W;

    logic     hit;
    logic     upper_ok;
    reg_ofs_e ofs;
    wdt_cfg_t cfg_q;
    logic [DATA_W-1:0] rdata_q;

    generate
        if (ADDR_W > IDX_LSB + 2) begin : g_upper
            assign upper_ok = (addr[ADDR_W-1:IDX_LSB+2] == '0);
        end else begin : g_no_upper
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign hit = upper_ok && (addr[IDX_LSB-1:0] == '0);
    assign ofs = reg_ofs_e'(addr[IDX_LSB+:2]);

    assign soft_wr_o   = wr_en && hit && (ofs == OFS_SOFT) && wbit_soft;
    assign kick_a_wr_o = wr_en && hit && (ofs == OFS_KICKA);
    assign kick_b_wr_o = wr_en && hit && (ofs == OFS_KICKB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_clr_i) begin
            cfg_q <= '0;
        end else begin
            if (wr_en && hit && (ofs == OFS_CFG)) begin
                cfg_q.en    <= wbit_en;
                cfg_q.delay <= wbit_delay;
            end
            if (en_clr_i) begin
                cfg_q.en <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en && hit) begin
            unique case (ofs)
                OFS_CFG:   rdata_q <= {cfg_q.en, {PAD_W{1'b0}}, cfg_q.delay};
                OFS_KICKA: rdata_q <= {{(DATA_W-CAUSE_W){1'b0}}, cause_i};
                default:   rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign cfg_o = cfg_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/seqkick_seq.sv
module seqkick_seq
    import seqkick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_a_wr_i,
    input  logic              kick_b_wr_i,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flush_i,
    output logic              good_o,
    output logic              bad_o
);

    kick_state_e state_q, state_d;
    logic a_match, b_match;

    assign a_match = (wdata == KICK_A_WORD);
    assign b_match = (wdata == KICK_B_WORD);

    always_comb begin
        state_d = state_q;
        if (flush_i) begin
            state_d = TK_WAIT;
        end else if (kick_a_wr_i) begin
            state_d = a_match ? TK_ARMED : TK_WAIT;
        end else if (kick_b_wr_i) begin
            state_d = TK_WAIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TK_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        good_o = 1'b0;
        bad_o  = 1'b0;
        unique case (state_q)
            TK_WAIT: begin
                bad_o = (kick_a_wr_i && !a_match) || kick_b_wr_i;
            end
            TK_ARMED: begin
                good_o = kick_b_wr_i && b_match;
                bad_o  = (kick_a_wr_i && !a_match) || (kick_b_wr_i && !b_match);
            end
            default: begin
                good_o = 1'b0;
                bad_o  = 1'b0;
            end
        endcase
    end

    // R4
    good_needs_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        good_o |-> (kick_b_wr_i && !bad_o));

endmodule

// File: rtl/seqkick_timer.sv
module seqkick_timer #(
    parameter int DELAY_W = 5,
    parameter int CNT_W   = 1 << DELAY_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               run_i,
    input  logic               tick_i,
    input  logic [DELAY_W-1:0] delay_i,
    output logic               expire_o
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0]   count_q;
    logic [CNT_W-1:0]   mask;
    logic [DELAY_W-1:0] sh;
    logic               terminal;

    assign sh       = DELAY_W'(CNT_W - 1) - delay_i;
    assign mask     = ALL_ONES >> sh;
    assign terminal = (count_q == mask);
    assign expire_o = run_i && tick_i && terminal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clr_i) begin
            count_q <= '0;
        end else if (run_i && tick_i) begin
            count_q <= terminal ? '0 : count_q + 1'b1;
        end
    end

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (count_q <= mask));

    // R11
    idle_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clr_i) |=> $stable(count_q));

endmodule

// File: rtl/seqkick_ctrl.sv
module seqkick_ctrl
    import seqkick_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               good_i,
    input  logic               bad_i,
    input  logic               soft_i,
    input  logic               expire_i,
    input  logic               user_rst_i,
    input  wdt_cfg_t           cfg_i,
    output logic               run_o,
    output logic [DELAY_W-1:0] act_delay_o,
    output logic               rst_req_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               timer_clr_o,
    output logic               seq_flush_o,
    output logic               en_clr_o,
    output logic               cfg_clr_o
);

    localparam int PC_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_LEN - 1);

    ctrl_state_e state_q, state_d;
    cause_e      cause_q, cause_d;
    logic [PC_W-1:0]    pcnt_q;
    logic [DELAY_W-1:0] act_delay_q;
    logic               load_act;
    logic               reload;
    logic               pulse_done;

    assign pulse_done = (state_q == ST_PULSE) && (pcnt_q == PC_LAST);

    // next-state and transition selection
    always_comb begin
        state_d  = state_q;
        cause_d  = cause_q;
        load_act = 1'b0;
        reload   = 1'b0;
        if (user_rst_i) begin
            state_d = ST_IDLE;
            cause_d = CAUSE_USER;
            reload  = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (soft_i) begin
                        state_d = ST_PULSE;
                        cause_d = CAUSE_SOFT;
                    end else if (good_i) begin
                        load_act = 1'b1;
                        reload   = 1'b1;
                        state_d  = cfg_i.en ? ST_RUN : ST_IDLE;
                    end
                end
                ST_RUN: begin
                    if (soft_i) begin
                        state_d = ST_PULSE;
                        cause_d = CAUSE_SOFT;
                    end else if (bad_i) begin
                        state_d = ST_PULSE;
                        cause_d = CAUSE_BADKICK;
                    end else if (good_i) begin
                        load_act = 1'b1;
                        reload   = 1'b1;
                        state_d  = cfg_i.en ? ST_RUN : ST_IDLE;
                    end else if (expire_i) begin
                        state_d = ST_PULSE;
                        cause_d = CAUSE_EXPIRE;
                    end
                end
                ST_PULSE: begin
                    if (pulse_done) state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cause_q     <= CAUSE_POWER;
            pcnt_q      <= '0;
            act_delay_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            if (state_d == ST_PULSE && state_q != ST_PULSE) pcnt_q <= '0;
            else if (state_q == ST_PULSE)                   pcnt_q <= pcnt_q + 1'b1;
            if (load_act) act_delay_q <= cfg_i.delay;
        end
    end

    // outputs
    always_comb begin
        run_o       = (state_q == ST_RUN);
        rst_req_o   = (state_q == ST_PULSE);
        timer_clr_o = reload || (state_q == ST_PULSE);
        seq_flush_o = user_rst_i || (state_q == ST_PULSE);
        en_clr_o    = pulse_done && !user_rst_i;
        cfg_clr_o   = user_rst_i;
        cause_o     = cause_q;
        act_delay_o = act_delay_q;
    end

    // R7
    soft_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_i && !user_rst_i && state_q != ST_PULSE) |=> (rst_req_o && cause_q == CAUSE_SOFT));

    // R5
    bad_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_i && state_q == ST_RUN && !soft_i && !user_rst_i) |=> (rst_req_o && cause_q == CAUSE_BADKICK));

    // R9
    user_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user_rst_i |=> (!rst_req_o && cause_q == CAUSE_USER));

    // R10
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cause_q) |-> ($rose(rst_req_o) || $past(user_rst_i)));

endmodule

// File: rtl/seqkick_wdt.sv
module seqkick_wdt
    import seqkick_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user_rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rst_req
);

    localparam int CNT_W = 1 << DELAY_W;

    wdt_cfg_t           cfg;
    logic               soft_wr, kick_a_wr, kick_b_wr;
    logic               good, bad, expire;
    logic               run, timer_clr, seq_flush, en_clr, cfg_clr;
    logic [DELAY_W-1:0] act_delay;
    logic [CAUSE_W-1:0] cause;

    seqkick_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .wbit_en    (wdata[DATA_W-1]),
        .wbit_delay (wdata[DELAY_W-1:0]),
        .wbit_soft  (wdata[0]),
        .cause_i    (cause),
        .cfg_clr_i  (cfg_clr),
        .en_clr_i   (en_clr),
        .cfg_o      (cfg),
        .soft_wr_o  (soft_wr),
        .kick_a_wr_o(kick_a_wr),
        .kick_b_wr_o(kick_b_wr),
        .rdata      (rdata)
    );

    seqkick_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_a_wr_i(kick_a_wr),
        .kick_b_wr_i(kick_b_wr),
        .wdata      (wdata),
        .flush_i    (seq_flush),
        .good_o     (good),
        .bad_o      (bad)
    );

    seqkick_timer #(.DELAY_W(DELAY_W), .CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (timer_clr),
        .run_i   (run),
        .tick_i  (tick),
        .delay_i (act_delay),
        .expire_o(expire)
    );

    seqkick_ctrl #(.PULSE_LEN(PULSE_LEN)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .good_i     (good),
        .bad_i      (bad),
        .soft_i     (soft_wr),
        .expire_i   (expire),
        .user_rst_i (user_rst),
        .cfg_i      (cfg),
        .run_o      (run),
        .act_delay_o(act_delay),
        .rst_req_o  (rst_req),
        .cause_o    (cause),
        .timer_clr_o(timer_clr),
        .seq_flush_o(seq_flush),
        .en_clr_o   (en_clr),
        .cfg_clr_o  (cfg_clr)
    );

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> !cfg.en);

    // R3
    expire_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (run && tick));

endmodule

// File: tb/seqkick_wdt_tb_top.sv
module seqkick_wdt_tb_top;

    localparam logic [31:0] KA = 32'hABCD1234;
    localparam logic [31:0] KB = 32'h4321DCBA;

    typedef struct packed {
        logic        is_wr;
        logic [3:0]  a;
        logic [31:0] d;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'h4, 32'hFFFF_FFFF},
        '{1'b0, 4'h4, 32'h8000_001F},
        '{1'b1, 4'h4, 32'h7FFF_FFE5},
        '{1'b0, 4'h4, 32'h0000_0005},
        '{1'b0, 4'h0, 32'h0000_0000},
        '{1'b0, 4'hC, 32'h0000_0000},
        '{1'b0, 4'h8, 32'h0000_0000},
        '{1'b1, 4'h4, 32'h0000_0000},
        '{1'b0, 4'h4, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        user_rst = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seqkick_wdt dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .user_rst(user_rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wdata   (wdata),
        .rdata   (rdata),
        .rst_req (rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // all tasks are entered at a falling edge and return at one
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic service();
        bus_wr(4'h8, KA);
        bus_wr(4'hC, KB);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] rv;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 power-on state
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
        bus_rd(4'h8, rv); chk("R1 cause", rv, 32'h0);
        bus_rd(4'h4, rv); chk("R1 cfg", rv, 32'h0);

        // R2 table of register accesses
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_wr) bus_wr(VECS[i].a, VECS[i].d);
            else begin
                bus_rd(VECS[i].a, rv);
                chk("R2 table read", rv, VECS[i].d);
            end
        end
        bus_rd(4'h6, rv); chk("R2 misaligned read", rv, 32'h0);

        // R3 config write alone does not start the timer
        bus_wr(4'h4, 32'h8000_0002);
        idle(20);
        chk("R3 staged cfg", {31'b0, rst_req}, 32'h0);
        service();
        idle(7); chk("R3 before expiry", {31'b0, rst_req}, 32'h0);
        idle(1); chk("R3 at expiry", {31'b0, rst_req}, 32'h1);
        idle(3); chk("R8 pulse held", {31'b0, rst_req}, 32'h1);
        idle(1); chk("R8 pulse ended", {31'b0, rst_req}, 32'h0);
        bus_rd(4'h8, rv); chk("R3 cause expiry", rv, 32'h1);
        bus_rd(4'h4, rv); chk("R8 enable cleared", rv, 32'h2);

        // R4 periodic service with interleaved access keeps it alive
        bus_wr(4'h4, 32'h8000_0003);
        service();
        for (int k = 0; k < 4; k++) begin
            idle(10);
            bus_wr(4'h8, KA);
            bus_rd(4'h4, rv);
            bus_wr(4'hC, KB);
        end
        idle(10);
        chk("R4 kept alive", {31'b0, rst_req}, 32'h0);

        // R5 wrong first word while running
        bus_wr(4'h8, 32'h1234_5678);
        chk("R5 bad word A", {31'b0, rst_req}, 32'h1);
        idle(5);
        bus_rd(4'h8, rv); chk("R5 cause bad", rv, 32'h2);

        // R5 second word without first, while running
        bus_wr(4'h4, 32'h8000_0004);
        service();
        idle(3);
        bus_wr(4'hC, KB);
        chk("R5 B without A", {31'b0, rst_req}, 32'h1);
        idle(5);

        // R5 bad writes while stopped are ignored
        bus_wr(4'h8, 32'hDEAD_BEEF);
        bus_wr(4'hC, 32'h0);
        idle(2);
        chk("R5 stopped ignore", {31'b0, rst_req}, 32'h0);
        bus_rd(4'h8, rv); chk("R5 cause unchanged", rv, 32'h2);

        // R6 clearing enable while running does not stop it
        bus_wr(4'h4, 32'h8000_0002);
        service();
        bus_wr(4'h4, 32'h0000_0002);
        idle(6); chk("R6 still counting", {31'b0, rst_req}, 32'h0);
        idle(1); chk("R6 expires", {31'b0, rst_req}, 32'h1);
        idle(5);

        // R6 stop takes effect at the next valid service
        bus_wr(4'h4, 32'h8000_0004);
        service();
        bus_wr(4'h4, 32'h0000_0004);
        service();
        idle(80);
        chk("R6 stopped", {31'b0, rst_req}, 32'h0);
        bus_rd(4'h8, rv); chk("R10 cause persists", rv, 32'h1);

        // R7 soft reset
        bus_wr(4'h0, 32'hFFFF_FFFE);
        chk("R7 bit0 clear", {31'b0, rst_req}, 32'h0);
        bus_wr(4'h0, 32'h1);
        chk("R7 soft pulse", {31'b0, rst_req}, 32'h1);
        idle(5);
        bus_rd(4'h8, rv); chk("R7 cause soft", rv, 32'h3);

        // R9 user reset while running
        bus_wr(4'h4, 32'h8000_0003);
        service();
        idle(3);
        user_rst = 1'b1;
        idle(1);
        user_rst = 1'b0;
        chk("R9 no pulse", {31'b0, rst_req}, 32'h0);
        bus_rd(4'h8, rv); chk("R9 cause user", rv, 32'h4);
        bus_rd(4'h4, rv); chk("R9 cfg cleared", rv, 32'h0);
        idle(40);
        chk("R9 stopped", {31'b0, rst_req}, 32'h0);

        // R11 no ticks, no progress
        tick = 1'b0;
        bus_wr(4'h4, 32'h8000_0000);
        service();
        idle(20);
        chk("R11 frozen", {31'b0, rst_req}, 32'h0);
        tick = 1'b1;
        idle(1); chk("R11 first tick", {31'b0, rst_req}, 32'h0);
        idle(1); chk("R11 second tick", {31'b0, rst_req}, 32'h1);
        idle(5);

        // R1 power-on reset clears the cause
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        bus_rd(4'h8, rv); chk("R1 cause after reset", rv, 32'h0);
        bus_rd(4'h4, rv); chk("R1 cfg after reset", rv, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule